// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is an 8-bit synchronous serial port. It can act as the clocking end (master) or the clocked end (slave) of an SPI link. One shift register sends a byte on the serial output and, in the same eight SCK cycles, takes in a byte from the serial input, most significant bit first. A holding buffer sits between that shift register and a small register bus. The host writes the outgoing byte into the buffer and reads the incoming byte back from it.

A configuration register sets the role, the SCK idle level and, for a master, where the bit clock comes from. The bit clock can be the system clock divided by 4, 16 or 64, or an external timer pulse divided by 2. For a slave, the same register sets whether the active-low select input gates the port. A buffer-full flag, a write-collision flag and an overflow flag can be read through a status register.

Top module: `spi_port`

## Requirements
- R1: A master transfer sends the written byte on `sdo`, MSB first, and receives 8 bits from `sdi` at the same time. After the transfer the received byte is read from address 0.
- R2: The control register's bit 4 sets the SCK idle level. `sck_out` holds that level whenever no master transfer runs. Data is sampled on the edge that leaves the idle level and launched on the edge that returns to it.
- R3: Control bits [3:0] select the master bit clock: 0 gives system clock / 4, 1 gives / 16, 2 gives / 64, and 3 gives one SCK edge per `timer_tick` pulse. With divider N, the buffer-full flag is set exactly 8·N clock edges after the edge that accepts the write.
- R4: In master mode, a write to address 0 while idle starts a transfer. A write to address 0 while a transfer runs is ignored, and it sets the write-collision flag (status bit 1).
- R5: When a byte completes and the buffer-full flag (status bit 0) is clear, the byte goes into the buffer and the flag is set. A read of address 0 clears the flag.
- R6: When a byte completes while the buffer-full flag is still set, the overflow flag (status bit 2) is set and the buffer keeps its prior contents.
- R7: Modes 4 and 5 make the port a slave. It samples and launches on the external `sck_in` by the same polarity rule, and shifts out the byte last written to address 0.
- R8: In mode 4, while `ss_n` is high, `sdo_en` is low and the bit count returns to zero, so a partly shifted byte is dropped.
- R9: In mode 5, `ss_n` has no effect: `sdo_en` stays high and transfers complete with `ss_n` high.
- R10: Address 1 reads back the 8-bit control register as written, and address 2 reads {5'b0, overflow, collision, full}. Writing address 2 with a 1 in bit 1 clears the collision flag, and with a 1 in bit 2 clears the overflow flag. With enable (control bit 5) at 0, or with mode values 6 to 15, no transfer runs and `sdo_en` is low.
- R11: After reset, the control and status registers read 0, `sck_out` is 0 and `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a data read clears the full flag) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| timer_tick | input | 1 | One-cycle pulse from an external timer |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | Serial clock sampled in slave mode |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | High when `sdo` should be driven |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |

## Verification
In master mode, the full flag is due exactly 8·N edges after the write edge. The bench counts edges from that edge and compares the count at the first sample that sees the flag. It checks both the count itself and that the flag did not appear sooner. Register reads are combinational and are sampled half a cycle after the inputs are driven. A flag caused by a write is looked at on the falling edge that follows the accepting edge. In slave mode, the synchronizers add about three cycles of delay. The bench holds each SCK phase for eight cycles and samples `sdo` just before it drives the sampling edge, so the delay never reaches a check.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         timer_tick,
  output logic         sck_out,
  input  logic         sck_in,
  output logic         sdo,
  output logic         sdo_en,
  input  logic         sdi,
  input  logic         ss_n
);
  localparam int EW = $clog2(2 * W);
  localparam int BW = $clog2(W);
  localparam int CW = $clog2(DIV_C / 2) + 1;

  logic [7:0]    cfg;
  logic [3:0]    mode;
  logic          cpol, en;
  logic          is_master, is_slave, ss_on;
  logic [W-1:0]  hold_q, sr;
  logic          rxb, bf, wcol, ovf;
  logic          mbusy, sck_r;
  logic [EW-1:0] ec;
  logic [CW-1:0] dcnt;
  logic          sck_m, sck_s, sck_p, sdi_m, sdi_s, ss_m, ss_s;
  logic [BW-1:0] bc;
  logic          mid;
  logic          half_hit, tick, m_lead, m_trail, m_done;
  logic          ss_block, s_edge, s_lead, s_trail, s_done;
  logic          done, busy, accept, collide;
  logic          wr_data, wr_cfg, wr_stat, rd_data;
  logic [W-1:0]  new_byte;

  assign mode      = cfg[3:0];
  assign cpol      = cfg[4];
  assign en        = cfg[5];
  assign is_master = en && (mode <= 4'd3);
  assign is_slave  = en && (mode == 4'd4 || mode == 4'd5);
  assign ss_on     = (mode == 4'd4);

  assign wr_data = wr_en && addr == 2'd0;
  assign wr_cfg  = wr_en && addr == 2'd1;
  assign wr_stat = wr_en && addr == 2'd2;
  assign rd_data = rd_en && addr == 2'd0;

  always_comb begin
    case (mode[1:0])
      2'd0:    half_hit = dcnt == CW'(DIV_A / 2 - 1);
      2'd1:    half_hit = dcnt == CW'(DIV_B / 2 - 1);
      2'd2:    half_hit = dcnt == CW'(DIV_C / 2 - 1);
      default: half_hit = timer_tick;
    endcase
  end

  assign tick    = mbusy && half_hit;
  assign m_lead  = tick && !ec[0];
  assign m_trail = tick && ec[0];
  assign m_done  = m_trail && ec == EW'(2 * W - 1);

  assign ss_block = is_slave && ss_on && ss_s;
  assign s_edge   = is_slave && !ss_block && (sck_s != sck_p);
  assign s_lead   = s_edge && (sck_p == cpol);
  assign s_trail  = s_edge && (sck_p != cpol);
  assign s_done   = s_trail && bc == BW'(W - 1);

  assign done     = m_done || s_done;
  assign busy     = is_master ? mbusy : (is_slave && (bc != '0 || mid));
  assign accept   = wr_data && !busy;
  assign collide  = wr_data && busy;
  assign new_byte = {sr[W-2:0], rxb};

  assign sck_out = is_master ? sck_r : cpol;
  assign sdo     = sr[W-1];
  assign sdo_en  = is_master || (is_slave && !ss_block);

  always_comb begin
    case (addr)
      2'd0:    rdata = hold_q;
      2'd1:    rdata = W'(cfg);
      2'd2:    rdata = W'({ovf, wcol, bf});
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; mbusy <= 1'b0; ec <= '0; dcnt <= '0; sck_r <= 1'b0;
    end else if (wr_cfg) begin
      cfg <= wdata[7:0]; mbusy <= 1'b0; ec <= '0; dcnt <= '0; sck_r <= wdata[4];
    end else if (accept && is_master) begin
      mbusy <= 1'b1; ec <= '0; dcnt <= '0;
    end else if (mbusy) begin
      dcnt <= half_hit ? '0 : dcnt + 1'b1;
      if (half_hit) begin
        sck_r <= ~sck_r;
        ec    <= ec + 1'b1;
        if (m_done) mbusy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0; sck_s <= 1'b0; sck_p <= 1'b0;
      sdi_m <= 1'b0; sdi_s <= 1'b0; ss_m <= 1'b1; ss_s <= 1'b1;
      bc <= '0; mid <= 1'b0;
    end else begin
      sck_m <= sck_in; sck_s <= sck_m; sck_p <= sck_s;
      sdi_m <= sdi;    sdi_s <= sdi_m;
      ss_m  <= ss_n;   ss_s  <= ss_m;
      if (wr_cfg || ss_block) begin
        bc <= '0; mid <= 1'b0;
      end else if (s_lead) begin
        mid <= 1'b1;
      end else if (s_trail) begin
        mid <= 1'b0;
        bc  <= s_done ? '0 : bc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; sr <= '0; rxb <= 1'b0; bf <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
    end else begin
      if (m_lead)       rxb <= sdi;
      else if (s_lead)  rxb <= sdi_s;
      if (accept)                     sr <= wdata;
      else if (m_trail || s_trail)    sr <= new_byte;
      if (accept)                     hold_q <= wdata;
      else if (done && !bf)           hold_q <= new_byte;
      if (done && !bf)                bf <= 1'b1;
      else if (rd_data)               bf <= 1'b0;
      if (done && bf)                 ovf <= 1'b1;
      else if (wr_stat && wdata[2])   ovf <= 1'b0;
      if (collide)                    wcol <= 1'b1;
      else if (wr_stat && wdata[1])   wcol <= 1'b0;
    end
  end
endmodule

module spi_port_chk #(
  parameter int W = 8
)(
  input logic         clk,
  input logic         rst_n,
  input logic         is_master,
  input logic         mbusy,
  input logic         sck_out,
  input logic         cpol,
  input logic         done,
  input logic         bf,
  input logic         ovf,
  input logic         wcol,
  input logic         wr_data,
  input logic         busy,
  input logic         ss_block,
  input logic         sdo_en,
  input logic         rd_data,
  input logic [W-1:0] hold_q
);
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !mbusy) |-> sck_out == cpol);
  p_full_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bf) |=> bf);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !bf);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bf) |=> (ovf && $stable(hold_q)));
  p_collision_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol);
  p_ss_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_block |-> !sdo_en);
endmodule

bind spi_port spi_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .mbusy(mbusy),
  .sck_out(sck_out), .cpol(cpol), .done(done), .bf(bf), .ovf(ovf),
  .wcol(wcol), .wr_data(wr_data), .busy(busy), .ss_block(ss_block),
  .sdo_en(sdo_en), .rd_data(rd_data), .hold_q(hold_q)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       timer_tick = 1'b0;
  logic       sck_out, sdo, sdo_en, sdi;
  logic       sck_in = 1'b0, ss_n = 1'b1, sdi_drv = 1'b0;
  logic       slave_tb = 1'b0, cpol_tb = 1'b0;
  logic [7:0] bm_tx = 8'h00, bm_rx = 8'h00, bm_val = 8'h00;
  logic       bm_load = 1'b0, prev_sck = 1'b0;
  logic [2:0] tcnt = 3'd0;
  int         n_chk = 0, n_bad = 0, sck_moves = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .timer_tick(timer_tick),
    .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo), .sdo_en(sdo_en),
    .sdi(sdi), .ss_n(ss_n)
  );

  assign sdi = slave_tb ? sdi_drv : bm_tx[7];

  always @(posedge clk) begin
    tcnt       <= (tcnt == 3'd4) ? 3'd0 : tcnt + 3'd1;
    timer_tick <= (tcnt == 3'd4);
  end

  always @(negedge clk) begin
    if (bm_load) begin
      bm_tx <= bm_val; bm_rx <= 8'h00;
    end else if (sck_out != prev_sck) begin
      sck_moves <= sck_moves + 1;
      if (prev_sck == cpol_tb) bm_rx <= {bm_rx[6:0], sdo};
      else                     bm_tx <= {bm_tx[6:0], 1'b0};
    end
    prev_sck <= sck_out;
  end

  localparam logic [23:0] VEC [6] = '{
    {8'h20, 8'hA5, 8'h3C}, {8'h31, 8'h96, 8'hF0}, {8'h22, 8'h01, 8'h80},
    {8'h23, 8'h7E, 8'hC3}, {8'h30, 8'h5A, 8'h0F}, {8'h33, 8'hE7, 8'h18}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic load_model(logic [7:0] v);
    @(negedge clk); bm_val = v; bm_load = 1'b1;
    @(negedge clk); bm_load = 1'b0;
  endtask

  task automatic wait_full(output int cyc);
    cyc = 0; addr = 2'd2; #1;
    while (!rdata[0] && cyc < 5000) begin
      @(posedge clk); cyc++; @(negedge clk); #1;
    end
  endtask

  task automatic slave_xfer(int nbits, logic [7:0] mb, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sdi_drv = mb[7-i];
      repeat (8) @(negedge clk);
      cap = {cap[6:0], sdo};
      sck_in = ~cpol_tb;
      repeat (8) @(negedge clk);
      sck_in = cpol_tb;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, cap;
    int cyc, moves0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    bus_read(2'd1, d); check("R11 control", d, 8'h00);
    bus_read(2'd2, d); check("R11 status", d, 8'h00);
    check("R11 sck_out", sck_out, 1'b0);
    check("R11 sdo_en", sdo_en, 1'b0);

    // R1 R2 R3 R5 vector walk over master modes
    for (int i = 0; i < 6; i++) begin
      bus_write(2'd1, VEC[i][23:16]);
      cpol_tb = VEC[i][20];
      repeat (3) @(negedge clk);
      load_model(VEC[i][7:0]);
      check("R2 idle level", sck_out, VEC[i][20]);
      bus_write(2'd0, VEC[i][15:8]);
      wait_full(cyc);
      if (VEC[i][17:16] != 2'd3)
        check("R3 cycles to full", cyc, 8 * (VEC[i][17:16] == 2'd0 ? 4 : VEC[i][17:16] == 2'd1 ? 16 : 64));
      else
        check("R3 timer mode completes", cyc < 5000, 1'b1);
      check("R1 byte seen on sdo", bm_rx, VEC[i][15:8]);
      check("R2 idle after transfer", sck_out, VEC[i][20]);
      bus_read(2'd0, d); check("R1 received byte", d, VEC[i][7:0]);
      bus_read(2'd2, d); check("R5 read clears full", d, 8'h00);
    end

    // R4 write collision
    bus_write(2'd1, 8'h22); cpol_tb = 1'b0;
    repeat (3) @(negedge clk);
    load_model(8'h5A);
    bus_write(2'd0, 8'hC3);
    repeat (50) @(negedge clk);
    bus_write(2'd0, 8'h0F);
    bus_read(2'd2, d); check("R4 collision flag", d, 8'h02);
    wait_full(cyc);
    check("R4 ignored write keeps byte", bm_rx, 8'hC3);
    bus_read(2'd0, d); check("R4 received byte", d, 8'h5A);
    bus_write(2'd2, 8'h06);
    bus_read(2'd2, d); check("R10 status clear", d, 8'h00);

    // R6 overflow
    bus_write(2'd1, 8'h20);
    load_model(8'h81); bus_write(2'd0, 8'h11); wait_full(cyc);
    load_model(8'h42); bus_write(2'd0, 8'h22);
    repeat (60) @(negedge clk);
    bus_read(2'd2, d); check("R6 overflow flag", d, 8'h05);
    bus_read(2'd0, d); check("R6 buffer kept", d, 8'h22);
    bus_write(2'd2, 8'h04);

    // R10 readback and disabled port
    bus_write(2'd1, 8'hC3);
    bus_read(2'd1, d); check("R10 control readback", d, 8'hC3);
    moves0 = sck_moves;
    bus_write(2'd0, 8'h99);
    repeat (400) @(negedge clk);
    check("R10 disabled no sck", sck_moves - moves0, 0);
    bus_read(2'd2, d); check("R10 disabled no full", d, 8'h00);
    check("R10 disabled sdo_en", sdo_en, 1'b0);

    // R7 R9 slave, select ignored, cpol 0
    slave_tb = 1'b1; cpol_tb = 1'b0; sck_in = 1'b0; ss_n = 1'b1;
    bus_write(2'd1, 8'h25);
    bus_write(2'd0, 8'hA6);
    repeat (4) @(negedge clk);
    check("R9 sdo_en with ss high", sdo_en, 1'b1);
    slave_xfer(8, 8'h3C, cap);
    check("R7 slave sends", cap, 8'hA6);
    bus_read(2'd0, d); check("R9 slave received with ss high", d, 8'h3C);

    // R7 slave, select honoured, cpol 1
    cpol_tb = 1'b1; sck_in = 1'b1;
    bus_write(2'd1, 8'h34);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_write(2'd0, 8'h71);
    slave_xfer(8, 8'h96, cap);
    check("R7 slave sends cpol1", cap, 8'h71);
    bus_read(2'd0, d); check("R7 slave received cpol1", d, 8'h96);

    // R8 select abort
    cpol_tb = 1'b0; sck_in = 1'b0; ss_n = 1'b1;
    bus_write(2'd1, 8'h24);
    repeat (6) @(negedge clk);
    check("R8 sdo released", sdo_en, 1'b0);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 sdo driven", sdo_en, 1'b1);
    slave_xfer(3, 8'hFF, cap);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 released mid byte", sdo_en, 1'b0);
    bus_read(2'd2, d); check("R8 no full on abort", d, 8'h00);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_write(2'd0, 8'h4B);
    slave_xfer(8, 8'hE1, cap);
    check("R8 fresh byte sent", cap, 8'h4B);
    bus_read(2'd0, d); check("R8 count restarted", d, 8'hE1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule